// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a byte stream into a bit-synchronous HDLC line signal. Bytes arrive on a valid/ready interface with an end-of-frame marker. The block sends one line bit for each cycle in which the transmit bit enable is high. Each frame is placed between flags. An address field of one or two octets comes first, taken from configuration. The payload follows, then a frame check sequence of 16 or 32 bits. A zero is inserted wherever the content would otherwise carry six ones in a row.

When no frame is waiting, the line carries back-to-back flags. A programmable minimum number of flags separates consecutive frames, so a slow far-end receiver has time to close one frame before the next one opens. The block samples the check length, the address width and the address value at the moment a frame opens. These settings can change between frames without corrupting a frame that is already on the line.

Top module: `hdlc_tx`

## Requirements
- R1: The flag octet 0x7E opens and closes every frame. When no frame is pending, the line carries flags continuously. All octets go out least significant bit first.
- R2: After five consecutive 1 bits of address, payload or check content, the block inserts a 0 bit, including after the final check bit. The block never stuffs flag bits.
- R3: With `cfg_fcs32`=0 the check field is 16 bits. It uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to all ones, over the address and payload bits, and the register is inverted at the end. Bit 0 of the inverted register is sent first.
- R4: With `cfg_fcs32`=1 the check field is 32 bits. It uses the reflected polynomial 0xEDB88320, preset to all ones, and the register is inverted at the end. Bit 0 is sent first.
- R5: Between the last check bit of one frame and the address of the next, exactly G whole flags are sent when the next frame is already pending, where G is the effective gap. After reset, G flags come before the first frame.
- R6: `cfg_flag_gap` values 1 to 62 are used as given. A value of 0 acts as 1, and values above 62 act as 62.
- R7: With `cfg_addr_wide`=0 the address field is the single octet `cfg_addr[7:0]`. With `cfg_addr_wide`=1 it is `cfg_addr[7:0]` followed by `cfg_addr[15:8]`.
- R8: `in_ready` is high only in a bit-enable cycle that ends an address or payload octet, when the next payload octet is needed. It is never high while flags or check bits are sent. Each frame accepts exactly its payload bytes.
- R9: The block samples `cfg_fcs32`, `cfg_addr_wide` and `cfg_addr` when a frame opens. Changing them mid-frame affects only later frames.
- R10: During reset `tx_bit` is 1 and `in_ready` is 0. After reset the line starts with a flag.
- R11: `tx_bit` changes only on a clock edge where `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is sent per cycle with this high |
| cfg_flag_gap | input | GAP_W | Minimum flags between frames |
| cfg_fcs32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| cfg_addr_wide | input | 1 | 1 selects the two-octet address field |
| cfg_addr | input | 16 | Address octets (low octet sent first) |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| in_ready | output | 1 | Payload byte taken this cycle |
| tx_bit | output | 1 | Serial line bit |

## Verification
The assertions assume that once a frame has opened, the source keeps `in_valid` high with the next byte whenever `in_ready` can rise, until the byte marked last is taken. The assertions also assume that `in_valid` is high when a gap ends only if a complete frame is queued. The bench meets this by loading every frame of a scenario into its queue before releasing reset. It presents the head of that queue at all times, so the source never underruns. Bit enables are either held high or drawn at random, and configuration changes happen only between scenarios or after the first byte of a frame has been taken.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    PH_FLAG = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_FCS  = 2'd3
  } phase_t;

  localparam int unsigned OCT_W     = 8;
  localparam int unsigned FCS_W     = 32;
  localparam logic [7:0]  FLAG_OCT  = 8'h7E;
  localparam logic [15:0] POLY16_RV = 16'h8408;
  localparam logic [31:0] POLY32_RV = 32'hEDB88320;

  // one serial step of the reflected 16-bit check
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc16_step = {1'b0, c[15:1]} ^ (fb ? POLY16_RV : 16'h0000);
  endfunction

  // one serial step of the reflected 32-bit check
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc32_step = {1'b0, c[31:1]} ^ (fb ? POLY32_RV : 32'h0000_0000);
  endfunction

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic             din,
  input  logic             use32,
  output logic [FCS_W-1:0] crc_q,
  output logic [FCS_W-1:0] crc_nx
);

  always_comb begin
    crc_nx = crc_q;
    if (en) begin
      if (use32) crc_nx = crc32_step(crc_q, din);
      else       crc_nx = {crc_q[FCS_W-1:16], crc16_step(crc_q[15:0], din)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else           crc_q <= crc_nx;
  end

endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic content,
  input  logic bit_in,
  output logic stuff_now
);

  localparam int OW = $clog2(RUN_LEN + 1);

  logic [OW-1:0] ones_q;

  assign stuff_now = (ones_q == OW'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else if (step) begin
      if (stuff_now || !content || !bit_in) ones_q <= '0;
      else                                  ones_q <= ones_q + OW'(1);
    end
  end

  // R2: the run of content ones never exceeds the stuffing limit
  a_r2_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(RUN_LEN));

endmodule

// File: rtl/hdlc_tx_gap.sv
module hdlc_tx_gap #(
  parameter int GAP_W   = 6,
  parameter int MAX_GAP = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             flag_done,
  input  logic             clear,
  output logic             gap_ok
);

  localparam logic [GAP_W-1:0] MAXV = GAP_W'(MAX_GAP);
  localparam logic [GAP_W-1:0] TOPV = '1;

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] eff;

  always_comb begin
    if (cfg_gap == '0)      eff = GAP_W'(1);
    else if (cfg_gap > MAXV) eff = MAXV;
    else                     eff = cfg_gap;
  end

  // true when the flag now finishing brings the count up to the gap
  assign gap_ok = ({1'b0, cnt_q} + (GAP_W+1)'(1)) >= {1'b0, eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clear)                     cnt_q <= '0;
    else if (flag_done && cnt_q != TOPV) cnt_q <= cnt_q + GAP_W'(1);
  end

  // R5: a frame may open only once the gap is reached
  a_r5_open_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> (cnt_q >= eff - GAP_W'(1)));

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int GAP_W   = 6,
  parameter int MAX_GAP = 62,
  parameter int RUN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [GAP_W-1:0] cfg_flag_gap,
  input  logic             cfg_fcs32,
  input  logic             cfg_addr_wide,
  input  logic [15:0]      cfg_addr,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             tx_bit
);

  localparam int CNT_W = $clog2(FCS_W);

  phase_t             phase_q;
  logic [FCS_W-1:0]   sh_q;
  logic [CNT_W-1:0]   bcnt_q;
  logic [CNT_W-1:0]   unit_last;
  logic               wide_q, fcs32_q, hi_q, last_q;
  logic [OCT_W-1:0]   addr_hi_q;

  logic stuff_now, gap_ok;
  logic unit_end, adv, is_content, line_bit, crc_en;
  logic flag_done, frame_start, addr_done, take_byte, fcs_load, fcs_done;
  logic [FCS_W-1:0] crc_q, crc_nx;

  // event decode, kept as named wires for the assertions
  always_comb begin
    unit_last   = (phase_q == PH_FCS) ? (fcs32_q ? CNT_W'(31) : CNT_W'(15)) : CNT_W'(OCT_W - 1);
    unit_end    = (bcnt_q == unit_last);
    adv         = bit_en && !stuff_now;
    is_content  = (phase_q != PH_FLAG);
    line_bit    = stuff_now ? 1'b0 : sh_q[0];
    crc_en      = adv && (phase_q == PH_ADDR || phase_q == PH_DATA);
    flag_done   = adv && unit_end && (phase_q == PH_FLAG);
    frame_start = flag_done && gap_ok && in_valid;
    addr_done   = adv && unit_end && (phase_q == PH_ADDR);
    take_byte   = (addr_done && !(wide_q && !hi_q)) ||
                  (adv && unit_end && (phase_q == PH_DATA) && !last_q);
    fcs_load    = adv && unit_end && (phase_q == PH_DATA) && last_q;
    fcs_done    = adv && unit_end && (phase_q == PH_FCS);
  end

  assign in_ready = take_byte;

  hdlc_tx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (bit_en),
    .content   (is_content),
    .bit_in    (sh_q[0]),
    .stuff_now (stuff_now)
  );

  hdlc_tx_gap #(.GAP_W(GAP_W), .MAX_GAP(MAX_GAP)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_gap   (cfg_flag_gap),
    .flag_done (flag_done),
    .clear     (frame_start),
    .gap_ok    (gap_ok)
  );

  hdlc_tx_fcs u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (frame_start),
    .en     (crc_en),
    .din    (sh_q[0]),
    .use32  (fcs32_q),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_FLAG;
      sh_q      <= FCS_W'(FLAG_OCT);
      bcnt_q    <= '0;
      wide_q    <= 1'b0;
      fcs32_q   <= 1'b0;
      hi_q      <= 1'b0;
      last_q    <= 1'b0;
      addr_hi_q <= '0;
      tx_bit    <= 1'b1;
    end else begin
      if (bit_en) tx_bit <= line_bit;
      if (adv) begin
        bcnt_q <= unit_end ? '0 : bcnt_q + CNT_W'(1);
        sh_q   <= {1'b0, sh_q[FCS_W-1:1]};
        if (frame_start) begin
          phase_q   <= PH_ADDR;
          sh_q      <= FCS_W'(cfg_addr[7:0]);
          wide_q    <= cfg_addr_wide;
          fcs32_q   <= cfg_fcs32;
          addr_hi_q <= cfg_addr[15:8];
          hi_q      <= 1'b0;
          last_q    <= 1'b0;
        end else if (flag_done) begin
          sh_q <= FCS_W'(FLAG_OCT);
        end else if (addr_done && wide_q && !hi_q) begin
          sh_q <= FCS_W'(addr_hi_q);
          hi_q <= 1'b1;
        end else if (take_byte) begin
          phase_q <= PH_DATA;
          sh_q    <= FCS_W'(in_data);
          last_q  <= in_last;
        end else if (fcs_load) begin
          phase_q <= PH_FCS;
          sh_q    <= ~crc_nx;
        end else if (fcs_done) begin
          phase_q <= PH_FLAG;
          sh_q    <= FCS_W'(FLAG_OCT);
        end
      end
    end
  end

  // R2: an inserted bit appears on the line as a zero
  a_r2_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> !tx_bit);

  // R8: payload bytes are taken only inside the address/payload phases
  a_r8_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (phase_q == PH_ADDR || phase_q == PH_DATA));

  // R3: the check register is frozen while its value is being shifted out
  a_r3_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FCS) |=> $stable(crc_q));

  // R9: sampled configuration holds for the whole frame
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_FLAG && $past(phase_q) != PH_FLAG) |-> $stable({fcs32_q, wide_q, addr_hi_q}));

  // R11: the line bit moves only after an enabled edge
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

endmodule

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [5:0]  cfg_flag_gap = 6'd1;
  logic        cfg_fcs32 = 1'b0, cfg_addr_wide = 1'b0;
  logic [15:0] cfg_addr = 16'h0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        in_ready, tx_bit;

  always #5 clk = ~clk;

  hdlc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_flag_gap(cfg_flag_gap),
    .cfg_fcs32(cfg_fcs32), .cfg_addr_wide(cfg_addr_wide), .cfg_addr(cfg_addr),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int n_tests = 0, n_fail = 0;
  bit cap_q[$];
  bit exp_q[$];
  logic [8:0] in_q[$];
  int en_mode = 0;
  int hs_count = 0, rdy_viol = 0, hold_viol = 0;
  bit hs_pend = 0, armed = 0, done = 0;
  logic last_tx = 1'b1;
  logic        nx_fcs32, nx_wide;
  logic [15:0] nx_addr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // stimulus driver and line capture, away from the active edge
  initial forever begin
    @(negedge clk);
    if (rst_n && bit_en) cap_q.push_back(tx_bit);
    if (rst_n && !bit_en && tx_bit !== last_tx) hold_viol++;
    if (hs_pend) begin
      void'(in_q.pop_front());
      hs_count++;
      if (armed) begin
        cfg_fcs32 = nx_fcs32; cfg_addr_wide = nx_wide; cfg_addr = nx_addr; armed = 0;
      end
    end
    last_tx = tx_bit;
    bit_en = rst_n && ((en_mode == 0) ? 1'b1 : (($urandom % 3) != 0));
    in_valid = (in_q.size() > 0);
    if (in_valid) {in_last, in_data} = in_q[0];
    else {in_last, in_data} = 9'h0;
    #1;
    hs_pend = rst_n && in_valid && in_ready;
    if (in_ready && !bit_en) rdy_viol++;
  end

  function automatic int eff_gap(input int g);
    if (g == 0) return 1;
    if (g > 62) return 62;
    return g;
  endfunction

  function automatic logic [15:0] ref_fcs16(input bit q[$]);
    logic [15:0] r = 16'hFFFF;
    foreach (q[i]) r = (r >> 1) ^ (((r[0] ^ q[i]) == 1'b1) ? 16'h8408 : 16'h0);
    return ~r;
  endfunction

  function automatic logic [31:0] ref_fcs32(input bit q[$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (q[i]) r = (r >> 1) ^ (((r[0] ^ q[i]) == 1'b1) ? 32'hEDB88320 : 32'h0);
    return ~r;
  endfunction

  task automatic push_oct(inout bit q[$], input logic [7:0] v);
    for (int i = 0; i < 8; i++) q.push_back(v[i]);
  endtask

  task automatic add_flags(input int n);
    for (int k = 0; k < n; k++) push_oct(exp_q, 8'h7E);
  endtask

  // queue a frame for the source and append its expected line bits
  task automatic add_frame(input int gap, input bit f32, input bit wide,
                           input logic [15:0] addr, input bq_t d);
    bit raw[$];
    logic [31:0] f;
    int ones = 0;
    add_flags(eff_gap(gap));
    push_oct(raw, addr[7:0]);
    if (wide) push_oct(raw, addr[15:8]);
    foreach (d[i]) begin
      push_oct(raw, d[i]);
      in_q.push_back({(i == d.size() - 1), d[i]});
    end
    f = f32 ? ref_fcs32(raw) : {16'h0, ref_fcs16(raw)};
    for (int i = 0; i < (f32 ? 32 : 16); i++) raw.push_back(f[i]);
    foreach (raw[i]) begin
      exp_q.push_back(raw[i]);
      ones = raw[i] ? ones + 1 : 0;
      if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
    end
  endtask

  task automatic begin_scn(input int gap, input bit f32, input bit wide,
                           input logic [15:0] addr, input int mode);
    @(posedge clk); #2;
    rst_n = 1'b0;
    cap_q.delete(); exp_q.delete(); in_q.delete();
    cfg_flag_gap = 6'(gap); cfg_fcs32 = f32; cfg_addr_wide = wide; cfg_addr = addr;
    en_mode = mode; hs_count = 0; armed = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic end_scn(input string req, input string what, input int nbytes);
    int guard = 0, bad = -1;
    add_flags(2);
    @(posedge clk); #2;
    rst_n = 1'b1;
    while (cap_q.size() < exp_q.size() && guard < 20000) begin
      @(posedge clk); guard++;
    end
    foreach (exp_q[i])
      if (bad < 0 && (i >= cap_q.size() || cap_q[i] !== exp_q[i])) bad = i;
    check(bad < 0, req, {what, " first bad bit index"}, bad, -1);
    check(hs_count == nbytes, "R8", {what, " bytes taken"}, hs_count, nbytes);
  endtask

  function automatic bq_t rnd_bytes(input int n);
    bq_t q;
    for (int i = 0; i < n; i++) q.push_back(8'($urandom));
    return q;
  endfunction

  initial begin
    bit kv[$];
    string s = "123456789";
    void'($urandom(32'd20250611));
    foreach (s[i]) push_oct(kv, s[i]);
    check(ref_fcs16(kv) == 16'h906E, "R3", "bench 16-bit check vector", ref_fcs16(kv), 16'h906E);
    check(ref_fcs32(kv) == 32'hCBF43926, "R4", "bench 32-bit check vector", ref_fcs32(kv), 32'hCBF43926);

    // R1 R5 R7 R10: single byte, narrow address, gap 1, continuous enable
    begin_scn(1, 0, 0, 16'h0003, 0);
    @(negedge clk); #2;
    check(tx_bit === 1'b1 && in_ready === 1'b0, "R10", "reset outputs", {tx_bit, in_ready}, 2'b10);
    add_frame(1, 0, 0, 16'h0003, '{8'h01});
    add_frame(1, 0, 0, 16'h0003, '{8'h3C, 8'hC3});
    end_scn("R1", "flags and narrow frame", 3);

    // R4 R7: wide address, 32-bit check, random enables
    begin_scn(3, 1, 1, 16'hA5C3, 1);
    for (int k = 0; k < 3; k++) add_frame(3, 1, 1, 16'hA5C3, rnd_bytes(1 + $urandom % 6));
    end_scn("R4", "wide 32-bit frames", in_q.size());

    // R2 R6: all-ones content forces stuffing, gap 0 acts as 1
    begin_scn(0, 0, 1, 16'hFFFF, 0);
    add_frame(0, 0, 1, 16'hFFFF, '{8'hFF, 8'hFF, 8'hFF, 8'hFF});
    add_frame(0, 0, 1, 16'hFFFF, '{8'h7E, 8'hFF});
    end_scn("R2", "stuffing and gap 0", 6);

    // R6: gap above range acts as 62
    begin_scn(63, 1, 0, 16'h0081, 1);
    add_frame(63, 1, 0, 16'h0081, '{8'h55});
    add_frame(63, 1, 0, 16'h0081, '{8'hF8, 8'h1F});
    end_scn("R6", "gap clamp 62", 3);

    // R9: configuration changed after first byte of frame one
    begin_scn(2, 0, 0, 16'h0011, 1);
    nx_fcs32 = 1; nx_wide = 1; nx_addr = 16'hF07E; armed = 1;
    add_frame(2, 0, 0, 16'h0011, '{8'hAA, 8'hBB, 8'hCC});
    add_frame(2, 1, 1, 16'hF07E, '{8'h12, 8'h34});
    end_scn("R9", "mid-frame config change", 5);

    // R3 R5: random gap, 16-bit check, several random frames
    for (int r = 0; r < 2; r++) begin
      int g = 1 + $urandom % 5;
      logic [15:0] a = 16'($urandom);
      bit w = 1'($urandom);
      begin_scn(g, 0, w, a, r);
      for (int k = 0; k < 4; k++) add_frame(g, 0, w, a, rnd_bytes(1 + $urandom % 5));
      end_scn("R3", "random 16-bit frames", in_q.size());
    end

    check(rdy_viol == 0, "R8", "ready without bit enable", rdy_viol, 0);
    check(hold_viol == 0, "R11", "line moved without enable", hold_viol, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule